// File: doc/BRIEF.md
# Descriptor chain sequencer

This is the per-channel control unit that walks a linked chain of block descriptors held in memory. Software programs a head pointer and raises an enable. The sequencer reads the five words that every descriptor needs, one word per request, over a word-wide memory port. These words are the source address, the destination address, the next pointer, and the low and high control words. The sequencer presents them as channel register outputs and fires a one-cycle block start toward an external data mover.

When the mover reports that the block has finished, the sequencer writes the high control word back to the descriptor with its done flag set. It then either follows the next pointer or ends the transfer. The descriptor's optional status snapshot words are not touched.

The memory request channel is valid/ready. A request, once raised, keeps its address, direction and data stable until it is accepted. Exactly one request is outstanding at a time. The response channel is also valid/ready: the sequencer raises `mrsp_ready` only while it waits for the response to its accepted request, and a response counts only on a cycle where both are high. The block start, block done, enable and all event pulses are plain single-cycle control signals.

Top module: `dsc_chain_seq`

## Requirements
- R1: A descriptor at pointer P is fetched as five read requests to P, P+4, P+8, P+12 and P+16, in that order. No request is issued while an earlier one still awaits its response, and a stalled request keeps its address, direction and data unchanged.
- R2: `blk_start` pulses for one cycle only after all five words have arrived without error. At that point `ch_src`, `ch_dst`, `ch_next`, `ch_ctl_lo` and `ch_ctl_hi` equal words 0 to 4, and `xfer_type` equals control-low bits [22:20] (0 memory to memory, 1 memory to peripheral, 2 peripheral to memory, 3 peripheral to peripheral).
- R3: After `blk_done`, exactly one write request goes to P+16 with data equal to the fetched control-high word with bit 12 (done) set. Afterwards `ch_ctl_hi` shows bit 12 set. The words at P to P+12 are never written.
- R4: When control-low bit 28 (source chaining) or bit 27 (destination chaining) is set and the next pointer is nonzero, the next fetch starts at the next pointer.
- R5: When neither chaining bit is set, no further descriptor is fetched, even if the next pointer is nonzero, and `xfer_done` pulses for one cycle.
- R6: A next pointer of zero ends the chain even when chaining is enabled, with a one-cycle `xfer_done` pulse.
- R7: When control-low bit 0 (interrupt enable) is set, `irq_block` pulses after each write-back of that descriptor, and `irq_xfer` pulses together with `xfer_done` at the end of the chain. When bit 0 is clear, neither pulses.
- R8: An error response to a fetch or to a write-back pulses `err_pulse`, returns the sequencer to idle with `busy` low, and is followed by no further request and no `xfer_done`.
- R9: A rising edge of `enable` while idle starts a fetch at `head_ptr`. If `enable` is low when a write-back completes and the chain would continue, the sequencer goes idle with no further fetch and no `xfer_done`. A chain that ends naturally still gives `xfer_done`.
- R10: After reset, `busy`, `mreq_valid`, `blk_start` and every event pulse are low, and the channel register outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Software enable; rising edge starts a chain |
| head_ptr | input | ADDR_W | Address of the first descriptor |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request accepted |
| mreq_write | output | 1 | 1 = write request, 0 = read |
| mreq_addr | output | ADDR_W | Request byte address |
| mreq_wdata | output | 32 | Write data |
| mrsp_valid | input | 1 | Memory response valid |
| mrsp_ready | output | 1 | Sequencer awaits a response |
| mrsp_rdata | input | 32 | Read data |
| mrsp_err | input | 1 | Response carries an error |
| blk_start | output | 1 | One-cycle block start to the mover |
| blk_done | input | 1 | One-cycle block completion from the mover |
| ch_src | output | 32 | Source address word |
| ch_dst | output | 32 | Destination address word |
| ch_next | output | 32 | Next descriptor pointer |
| ch_ctl_lo | output | 32 | Control low word |
| ch_ctl_hi | output | 32 | Control high word (size [11:0], done bit 12) |
| xfer_type | output | 3 | Transfer type field of control low |
| busy | output | 1 | Sequencer not idle |
| irq_block | output | 1 | Block completion interrupt pulse |
| irq_xfer | output | 1 | Transfer completion interrupt pulse |
| xfer_done | output | 1 | Chain finished pulse |
| err_pulse | output | 1 | Chain aborted on an error response |

## Verification
The assertions assume that memory drives `mrsp_valid` only while `mrsp_ready` is high, that the mover gives one `blk_done` per `blk_start`, and that `head_ptr` is steady while a chain runs. The bench keeps to this. Its memory model raises a response only after a request has been accepted and only while `mrsp_ready` is high. Its mover answers each start with a single done pulse after a random delay, and the pointer changes only between chains. Request back-pressure and response delays are random, so the hold and single-outstanding rules are exercised under stalls.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int WORD_BITS   = 32;
  localparam int WORD_BYTES  = WORD_BITS / 8;
  localparam int DESC_WORDS  = 5;
  localparam int IDX_W       = $clog2(DESC_WORDS);
  localparam int HI_INDEX    = 4;
  localparam int NEXT_INDEX  = 2;
  localparam int LO_INDEX    = 3;
  localparam int DONE_BIT    = 12;
  localparam int INT_EN_BIT  = 0;
  localparam int DST_CH_BIT  = 27;
  localparam int SRC_CH_BIT  = 28;
  localparam int TYPE_LSB    = 20;
  localparam int TYPE_W      = 3;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_FETCH, SQ_FWAIT, SQ_START, SQ_RUN, SQ_WB, SQ_WWAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    MP_IDLE, MP_REQ, MP_RSP
  } port_state_t;
endpackage

// File: rtl/dsc_mem_port.sv
module dsc_mem_port #(
  parameter int ADDR_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_go,
  input  logic                          cmd_wr,
  input  logic [ADDR_W-1:0]             cmd_addr,
  input  logic [dsc_pkg::WORD_BITS-1:0] cmd_wdata,
  output logic                          mreq_valid,
  input  logic                          mreq_ready,
  output logic                          mreq_write,
  output logic [ADDR_W-1:0]             mreq_addr,
  output logic [dsc_pkg::WORD_BITS-1:0] mreq_wdata,
  input  logic                          mrsp_valid,
  output logic                          mrsp_ready,
  input  logic                          mrsp_err,
  output logic                          rsp_done,
  output logic                          rsp_fail
);
  import dsc_pkg::*;

  port_state_t pstate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pstate     <= MP_IDLE;
      mreq_write <= 1'b0;
      mreq_addr  <= '0;
      mreq_wdata <= '0;
    end else begin
      unique case (pstate)
        MP_IDLE: if (cmd_go) begin
          pstate     <= MP_REQ;
          mreq_write <= cmd_wr;
          mreq_addr  <= cmd_addr;
          mreq_wdata <= cmd_wdata;
        end
        MP_REQ:  if (mreq_ready) pstate <= MP_RSP;
        MP_RSP:  if (mrsp_valid) pstate <= MP_IDLE;
        default: pstate <= MP_IDLE;
      endcase
    end
  end

  assign mreq_valid = (pstate == MP_REQ);
  assign mrsp_ready = (pstate == MP_RSP);
  assign rsp_done   = mrsp_ready && mrsp_valid;
  assign rsp_fail   = rsp_done && mrsp_err;
endmodule

// File: rtl/dsc_desc_regs.sv
module dsc_desc_regs #(
  parameter int NUM_WORDS = dsc_pkg::DESC_WORDS
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          ld_en,
  input  logic [dsc_pkg::IDX_W-1:0]                     ld_idx,
  input  logic [dsc_pkg::WORD_BITS-1:0]                 ld_data,
  input  logic                                          done_set,
  output logic [NUM_WORDS-1:0][dsc_pkg::WORD_BITS-1:0]  words
);
  import dsc_pkg::*;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    if (i == HI_INDEX) begin : g_hi
      always_ff @(posedge clk) begin
        if (!rst_n)                             words[i] <= '0;
        else if (ld_en && ld_idx == IDX_W'(i))  words[i] <= ld_data;
        else if (done_set)                      words[i][DONE_BIT] <= 1'b1;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)                             words[i] <= '0;
        else if (ld_en && ld_idx == IDX_W'(i))  words[i] <= ld_data;
      end
    end
  end
endmodule

// File: rtl/dsc_seq_ctrl.sv
module dsc_seq_ctrl #(
  parameter int ADDR_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enable,
  input  logic [ADDR_W-1:0]             head_ptr,
  input  logic [dsc_pkg::WORD_BITS-1:0] next_word,
  input  logic [dsc_pkg::WORD_BITS-1:0] hi_word,
  input  logic                          int_en,
  input  logic                          src_chain,
  input  logic                          dst_chain,
  input  logic                          blk_done,
  input  logic                          rsp_done,
  input  logic                          rsp_fail,
  output logic                          cmd_go,
  output logic                          cmd_wr,
  output logic [ADDR_W-1:0]             cmd_addr,
  output logic [dsc_pkg::WORD_BITS-1:0] cmd_wdata,
  output logic                          ld_en,
  output logic [dsc_pkg::IDX_W-1:0]     ld_idx,
  output logic                          done_set,
  output logic                          blk_start,
  output logic                          busy,
  output logic                          irq_block,
  output logic                          irq_xfer,
  output logic                          xfer_done,
  output logic                          err_pulse
);
  import dsc_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);
  localparam int               OFS_SH   = $clog2(WORD_BYTES);

  seq_state_t        state;
  logic [ADDR_W-1:0] ptr;
  logic [IDX_W-1:0]  idx;
  logic              en_q;
  logic              go_on;
  logic              ok_rsp;

  assign go_on  = (src_chain || dst_chain) && (next_word != '0);
  assign ok_rsp = rsp_done && !rsp_fail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      ptr       <= '0;
      idx       <= '0;
      en_q      <= 1'b0;
      irq_block <= 1'b0;
      irq_xfer  <= 1'b0;
      xfer_done <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      en_q      <= enable;
      irq_block <= 1'b0;
      irq_xfer  <= 1'b0;
      xfer_done <= 1'b0;
      err_pulse <= 1'b0;
      unique case (state)
        SQ_IDLE: if (enable && !en_q) begin
          ptr   <= head_ptr;
          idx   <= '0;
          state <= SQ_FETCH;
        end
        SQ_FETCH: state <= SQ_FWAIT;
        SQ_FWAIT: if (rsp_fail) begin
          err_pulse <= 1'b1;
          state     <= SQ_IDLE;
        end else if (rsp_done) begin
          if (idx == LAST_IDX) state <= SQ_START;
          else begin
            idx   <= idx + 1'b1;
            state <= SQ_FETCH;
          end
        end
        SQ_START: state <= SQ_RUN;
        SQ_RUN:   if (blk_done) state <= SQ_WB;
        SQ_WB:    state <= SQ_WWAIT;
        SQ_WWAIT: if (rsp_fail) begin
          err_pulse <= 1'b1;
          state     <= SQ_IDLE;
        end else if (rsp_done) begin
          irq_block <= int_en;
          if (go_on && enable) begin
            ptr   <= ADDR_W'(next_word);
            idx   <= '0;
            state <= SQ_FETCH;
          end else if (go_on) begin
            state <= SQ_IDLE;
          end else begin
            xfer_done <= 1'b1;
            irq_xfer  <= int_en;
            state     <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_go    = (state == SQ_FETCH) || (state == SQ_WB);
    cmd_wr    = (state == SQ_WB);
    cmd_addr  = cmd_wr ? ptr + ADDR_W'(HI_INDEX << OFS_SH)
                       : ptr + (ADDR_W'(idx) << OFS_SH);
    cmd_wdata = hi_word | (WORD_BITS'(1) << DONE_BIT);
    ld_en     = (state == SQ_FWAIT) && ok_rsp;
    ld_idx    = idx;
    done_set  = (state == SQ_WWAIT) && ok_rsp;
    blk_start = (state == SQ_START);
    busy      = (state != SQ_IDLE);
  end
endmodule

// File: rtl/dsc_chain_seq.sv
module dsc_chain_seq #(
  parameter int ADDR_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enable,
  input  logic [ADDR_W-1:0]             head_ptr,
  output logic                          mreq_valid,
  input  logic                          mreq_ready,
  output logic                          mreq_write,
  output logic [ADDR_W-1:0]             mreq_addr,
  output logic [dsc_pkg::WORD_BITS-1:0] mreq_wdata,
  input  logic                          mrsp_valid,
  output logic                          mrsp_ready,
  input  logic [dsc_pkg::WORD_BITS-1:0] mrsp_rdata,
  input  logic                          mrsp_err,
  output logic                          blk_start,
  input  logic                          blk_done,
  output logic [dsc_pkg::WORD_BITS-1:0] ch_src,
  output logic [dsc_pkg::WORD_BITS-1:0] ch_dst,
  output logic [dsc_pkg::WORD_BITS-1:0] ch_next,
  output logic [dsc_pkg::WORD_BITS-1:0] ch_ctl_lo,
  output logic [dsc_pkg::WORD_BITS-1:0] ch_ctl_hi,
  output logic [dsc_pkg::TYPE_W-1:0]    xfer_type,
  output logic                          busy,
  output logic                          irq_block,
  output logic                          irq_xfer,
  output logic                          xfer_done,
  output logic                          err_pulse
);
  import dsc_pkg::*;

  logic                                 cmd_go, cmd_wr;
  logic [ADDR_W-1:0]                    cmd_addr;
  logic [WORD_BITS-1:0]                 cmd_wdata;
  logic                                 rsp_done, rsp_fail;
  logic                                 ld_en, done_set;
  logic [IDX_W-1:0]                     ld_idx;
  logic [DESC_WORDS-1:0][WORD_BITS-1:0] words;

  dsc_mem_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .cmd_go(cmd_go), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
    .mreq_addr(mreq_addr), .mreq_wdata(mreq_wdata),
    .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_err(mrsp_err),
    .rsp_done(rsp_done), .rsp_fail(rsp_fail)
  );

  dsc_desc_regs #(.NUM_WORDS(DESC_WORDS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(mrsp_rdata),
    .done_set(done_set), .words(words)
  );

  dsc_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .enable(enable), .head_ptr(head_ptr),
    .next_word(words[NEXT_INDEX]), .hi_word(words[HI_INDEX]),
    .int_en(words[LO_INDEX][INT_EN_BIT]),
    .src_chain(words[LO_INDEX][SRC_CH_BIT]),
    .dst_chain(words[LO_INDEX][DST_CH_BIT]),
    .blk_done(blk_done), .rsp_done(rsp_done), .rsp_fail(rsp_fail),
    .cmd_go(cmd_go), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .ld_en(ld_en), .ld_idx(ld_idx), .done_set(done_set),
    .blk_start(blk_start), .busy(busy),
    .irq_block(irq_block), .irq_xfer(irq_xfer),
    .xfer_done(xfer_done), .err_pulse(err_pulse)
  );

  assign ch_src    = words[0];
  assign ch_dst    = words[1];
  assign ch_next   = words[NEXT_INDEX];
  assign ch_ctl_lo = words[LO_INDEX];
  assign ch_ctl_hi = words[HI_INDEX];
  assign xfer_type = words[LO_INDEX][TYPE_LSB +: TYPE_W];
endmodule

// File: rtl/dsc_chain_seq_chk.sv
module dsc_chain_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mreq_valid,
  input logic              mreq_ready,
  input logic              mreq_write,
  input logic [ADDR_W-1:0] mreq_addr,
  input logic [31:0]       mreq_wdata,
  input logic              mrsp_valid,
  input logic              mrsp_ready,
  input logic              blk_start,
  input logic              busy,
  input logic              irq_xfer,
  input logic              xfer_done,
  input logic              err_pulse
);
  logic              outst;
  logic [2:0]        rd_cnt;
  logic [ADDR_W-1:0] last_rd;
  logic              req_hs, rsp_hs;

  assign req_hs = mreq_valid && mreq_ready;
  assign rsp_hs = mrsp_valid && mrsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst   <= 1'b0;
      rd_cnt  <= '0;
      last_rd <= '0;
    end else begin
      if (req_hs)      outst <= 1'b1;
      else if (rsp_hs) outst <= 1'b0;
      if (blk_start || err_pulse) rd_cnt <= '0;
      else if (req_hs && !mreq_write && rd_cnt != 3'd7) rd_cnt <= rd_cnt + 3'd1;
      if (req_hs && !mreq_write) last_rd <= mreq_addr;
    end
  end

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr)
      && $stable(mreq_write) && $stable(mreq_wdata));

  // R1
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_hs |-> !outst);

  // R1
  rsp_matches_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hs |-> outst);

  // R2
  start_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |-> rd_cnt == 3'd5);

  // R2
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> !blk_start);

  // R3
  wb_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && mreq_write |-> mreq_addr == last_rd && mreq_wdata[12]);

  // R7
  irq_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_xfer |-> xfer_done);

  // R8
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> !busy && !xfer_done);
endmodule

bind dsc_chain_seq dsc_chain_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
  .mreq_addr(mreq_addr), .mreq_wdata(mreq_wdata),
  .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready),
  .blk_start(blk_start), .busy(busy),
  .irq_xfer(irq_xfer), .xfer_done(xfer_done), .err_pulse(err_pulse)
);

// File: tb/tb_dsc_chain_seq.sv
module tb_dsc_chain_seq;
  localparam int EV_RD = 0, EV_WR = 1, EV_START = 2, EV_IRQB = 3,
                 EV_XDONE = 4, EV_IRQX = 5, EV_ERR = 6;

  typedef struct {
    int          kind;
    logic [31:0] a;
    logic [31:0] d0, d1, d2, d3, d4;
  } ev_t;

  logic        clk = 0, rst_n = 0, enable = 0;
  logic [31:0] head_ptr = 0;
  logic        mreq_valid, mreq_ready = 0, mreq_write;
  logic [31:0] mreq_addr, mreq_wdata;
  logic        mrsp_valid = 0, mrsp_ready, mrsp_err = 0;
  logic [31:0] mrsp_rdata = 0;
  logic        blk_start, blk_done = 0;
  logic [31:0] ch_src, ch_dst, ch_next, ch_ctl_lo, ch_ctl_hi;
  logic [2:0]  xfer_type;
  logic        busy, irq_block, irq_xfer, xfer_done, err_pulse;

  int checks = 0, errors = 0;
  logic [31:0] mem [int];
  ev_t expq[$];
  logic        rd_err_on = 0, wr_err_on = 0;
  logic [31:0] rd_err_at = 0, wr_err_at = 0;
  int          stop_k = 0, starts_seen = 0, mover_cnt = 0;
  logic        pend = 0, pend_err = 0, mon_on = 0;
  logic [31:0] pend_data = 0;
  int          pend_dly = 0;

  always #5 clk = ~clk;

  dsc_chain_seq #(.ADDR_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .head_ptr(head_ptr),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
    .mreq_addr(mreq_addr), .mreq_wdata(mreq_wdata),
    .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_rdata(mrsp_rdata),
    .mrsp_err(mrsp_err), .blk_start(blk_start), .blk_done(blk_done),
    .ch_src(ch_src), .ch_dst(ch_dst), .ch_next(ch_next),
    .ch_ctl_lo(ch_ctl_lo), .ch_ctl_hi(ch_ctl_hi), .xfer_type(xfer_type),
    .busy(busy), .irq_block(irq_block), .irq_xfer(irq_xfer),
    .xfer_done(xfer_done), .err_pulse(err_pulse)
  );

  function automatic logic [31:0] rdm(logic [31:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 32'h0;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input int kind, input logic [31:0] a, input logic [31:0] d);
    ev_t e;
    e.kind = kind; e.a = a; e.d0 = d; e.d1 = 0; e.d2 = 0; e.d3 = 0; e.d4 = 0;
    expq.push_back(e);
  endtask

  // Behavioural walk of the chain from the requirements (R1..R9)
  task automatic build_expect(input logic [31:0] p0, input int stopk);
    logic [31:0] p, lo, nx;
    int k;
    ev_t e;
    p = p0; k = 0;
    forever begin
      for (int i = 0; i < 5; i++) begin
        push(EV_RD, p + 32'(4 * i), 0);
        if (rd_err_on && p + 32'(4 * i) == rd_err_at) begin
          push(EV_ERR, 0, 0); return;
        end
      end
      e.kind = EV_START; e.a = p;
      e.d0 = rdm(p); e.d1 = rdm(p + 4); e.d2 = rdm(p + 8);
      e.d3 = rdm(p + 12); e.d4 = rdm(p + 16);
      expq.push_back(e);
      k++;
      push(EV_WR, p + 16, rdm(p + 16) | 32'h1000);
      if (wr_err_on && p + 16 == wr_err_at) begin push(EV_ERR, 0, 0); return; end
      lo = rdm(p + 12); nx = rdm(p + 8);
      if (lo[0]) push(EV_IRQB, 0, 0);
      if ((lo[28] || lo[27]) && nx != 0) begin
        if (k == stopk) return;
        p = nx;
      end else begin
        push(EV_XDONE, 0, 0);
        if (lo[0]) push(EV_IRQX, 0, 0);
        return;
      end
    end
  endtask

  task automatic expect_ev(input int kind, input string req, output ev_t e);
    if (expq.size() == 0) begin
      chk(0, req, 32'(kind), 32'hFFFFFFFF);
      e.kind = -1; e.a = 0; e.d0 = 0; e.d1 = 0; e.d2 = 0; e.d3 = 0; e.d4 = 0;
    end else begin
      e = expq.pop_front();
      chk(e.kind == kind, req, 32'(kind), 32'(e.kind));
    end
  endtask

  // Memory, mover and per-cycle comparison against the model
  initial begin
    ev_t e;
    logic r;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (mrsp_valid) begin
          mrsp_valid = 0; mrsp_err = 0;
        end else if (pend && mrsp_ready) begin
          if (pend_dly > 0) pend_dly--;
          else begin
            mrsp_valid = 1; mrsp_rdata = pend_data; mrsp_err = pend_err; pend = 0;
          end
        end
        r = ($urandom % 4) != 0;
        mreq_ready = r;
        if (mreq_valid && r) begin
          expect_ev(mreq_write ? EV_WR : EV_RD, "R1/R3 request kind", e);
          chk(mreq_addr == e.a, "R1/R3 request address", mreq_addr, e.a);
          if (mreq_write) begin
            chk(mreq_wdata == e.d0, "R3 write-back data", mreq_wdata, e.d0);
            mem[int'(mreq_addr)] = mreq_wdata;
            pend_err = wr_err_on && mreq_addr == wr_err_at;
            pend_data = 0;
          end else begin
            pend_err = rd_err_on && mreq_addr == rd_err_at;
            pend_data = rdm(mreq_addr);
          end
          pend = 1; pend_dly = $urandom % 3;
        end
        if (blk_done) blk_done = 0;
        else if (mover_cnt > 0) begin
          mover_cnt--;
          if (mover_cnt == 0) blk_done = 1;
        end
        if (blk_start) begin
          expect_ev(EV_START, "R2 block start", e);
          chk(ch_src == e.d0, "R2 ch_src", ch_src, e.d0);
          chk(ch_dst == e.d1, "R2 ch_dst", ch_dst, e.d1);
          chk(ch_next == e.d2, "R2 ch_next", ch_next, e.d2);
          chk(ch_ctl_lo == e.d3, "R2 ch_ctl_lo", ch_ctl_lo, e.d3);
          chk(ch_ctl_hi == e.d4, "R2 ch_ctl_hi", ch_ctl_hi, e.d4);
          chk(xfer_type == e.d3[22:20], "R2 xfer_type", 32'(xfer_type), 32'(e.d3[22:20]));
          mover_cnt = 1 + $urandom % 5;
          starts_seen++;
          if (starts_seen == stop_k) enable = 0;
        end
        if (irq_block) expect_ev(EV_IRQB, "R7 irq_block", e);
        if (xfer_done) expect_ev(EV_XDONE, "R5/R6 xfer_done", e);
        if (irq_xfer)  expect_ev(EV_IRQX, "R7 irq_xfer", e);
        if (err_pulse) expect_ev(EV_ERR, "R8 err_pulse", e);
      end
    end
  end

  task automatic mk_desc(input logic [31:0] p, input logic [31:0] s, input logic [31:0] d,
                         input logic [31:0] nx, input logic [31:0] lo, input logic [31:0] hi);
    mem[int'(p)] = s; mem[int'(p + 4)] = d; mem[int'(p + 8)] = nx;
    mem[int'(p + 12)] = lo; mem[int'(p + 16)] = hi;
  endtask

  task automatic run_case(input string req, input logic [31:0] p0, input int stopk);
    int n;
    build_expect(p0, stopk);
    stop_k = stopk; starts_seen = 0;
    @(negedge clk);
    head_ptr = p0; enable = 1;
    repeat (3) @(negedge clk);
    n = 0;
    while ((busy || expq.size() != 0) && n < 5000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, {req, " all expected events seen"}, 32'(expq.size()), 0);
    chk(!busy, {req, " idle at end"}, 32'(busy), 0);
    enable = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(!busy && !mreq_valid && !blk_start, "R10 control idle after reset",
        {29'b0, busy, mreq_valid, blk_start}, 0);
    chk(!irq_block && !irq_xfer && !xfer_done && !err_pulse, "R10 pulses low",
        {28'b0, irq_block, irq_xfer, xfer_done, err_pulse}, 0);
    chk((ch_src | ch_dst | ch_next | ch_ctl_lo | ch_ctl_hi) == 0, "R10 channel regs zero",
        ch_src | ch_dst | ch_next | ch_ctl_lo | ch_ctl_hi, 0);
    mon_on = 1;

    // R5 R7 R2: no chaining bits, nonzero next, interrupts on, type 2
    mk_desc(32'h100, 32'hA000_0000, 32'hB000_0000, 32'h200, 32'h0020_0001, 32'h0000_0040);
    mk_desc(32'h200, 32'h1, 32'h2, 32'h0, 32'h1800_0001, 32'h1);
    run_case("R5", 32'h100, 0);
    // R3 memory side of the write-back
    chk(rdm(32'h110) == 32'h0000_1040, "R3 control-high in memory", rdm(32'h110), 32'h1040);
    chk(rdm(32'h100) == 32'hA000_0000 && rdm(32'h104) == 32'hB000_0000 &&
        rdm(32'h108) == 32'h200 && rdm(32'h10C) == 32'h0020_0001,
        "R3 first four words unchanged", rdm(32'h10C), 32'h0020_0001);
    chk(ch_ctl_hi[12], "R3 ch_ctl_hi done flag", ch_ctl_hi, 32'h1040);

    // R4 R6 R7: source chain, destination chain, both with next zero
    mk_desc(32'h1000, 32'h11, 32'h21, 32'h1040, 32'h1010_0001, 32'h8);
    mk_desc(32'h1040, 32'h12, 32'h22, 32'h1080, 32'h0830_0000, 32'h9);
    mk_desc(32'h1080, 32'h13, 32'h23, 32'h0,    32'h1800_0001, 32'hFFF);
    run_case("R4/R6", 32'h1000, 0);

    // R7: interrupts disabled, only xfer_done
    mk_desc(32'h1800, 32'h5, 32'h6, 32'h0, 32'h1000_0000, 32'h3);
    run_case("R7", 32'h1800, 0);

    // R8: fetch error on word 2
    mk_desc(32'h2000, 32'h7, 32'h8, 32'h2040, 32'h1000_0001, 32'h4);
    rd_err_on = 1; rd_err_at = 32'h2008;
    run_case("R8 fetch", 32'h2000, 0);
    rd_err_on = 0;

    // R8: write-back error on first of a chain
    mk_desc(32'h3000, 32'h9, 32'hA, 32'h3040, 32'h1000_0001, 32'h5);
    mk_desc(32'h3040, 32'hB, 32'hC, 32'h0, 32'h0000_0001, 32'h6);
    wr_err_on = 1; wr_err_at = 32'h3010;
    run_case("R8 write-back", 32'h3000, 0);
    wr_err_on = 0;

    // R9: enable dropped during first block of a three-long chain
    mk_desc(32'h4000, 32'hD, 32'hE, 32'h4040, 32'h1000_0001, 32'h7);
    mk_desc(32'h4040, 32'hF, 32'h10, 32'h4080, 32'h1000_0001, 32'h8);
    mk_desc(32'h4080, 32'h11, 32'h12, 32'h0, 32'h1000_0001, 32'h9);
    run_case("R9 stop", 32'h4000, 1);

    // R9: enable dropped on a chain that ends anyway, xfer_done still given
    mk_desc(32'h5000, 32'h13, 32'h14, 32'h0, 32'h0810_0001, 32'hA);
    run_case("R9 natural end", 32'h5000, 1);

    // R9 R1: restart from a new head after the stop, type 3
    mk_desc(32'h6000, 32'h15, 32'h16, 32'h0, 32'h0030_0000, 32'hB);
    run_case("R9 restart", 32'h6000, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule